// File: doc/BRIEF.md
# CPU Port-Write Capture Mailbox

This block sits between a CPU bus and a side controller that may be slow to respond. When the CPU performs an I/O write, the block holds the port address (the low byte of the address bus) and the data byte in two holding registers, then raises an interrupt request toward the controller. The CPU never waits.

The controller reads the held values when it is ready. It uses a small parallel mini-bus with a 4-bit register select and an active-low read strobe. Reading the data select completes the transaction and clears the request. The held values stay put for as long as the controller takes. If a second CPU write lands before the controller has collected the first, the newest values replace the old ones and an overrun flag records the loss.

The CPU control strobes are asynchronous to the system clock. They are synchronised, and the capture is committed when the write deasserts, so the held values are the final stable bus values. Two assumptions apply. A CPU write stays active across at least two rising clock edges. Consecutive writes are at least four clocks apart.

Top module: `iowr_mailbox`

## Requirements
- R1: After reset, the interrupt request is low, the overrun flag is clear, the held address and held data are 0x00, and `ctl_dout` is 0x00.
- R2: An I/O write is recognised only when `cpu_iorq_n` and `cpu_wr_n` are low together. Either one low on its own captures nothing, leaves the held values unchanged and raises no interrupt.
- R3: The held address and data are the bus values present in the last clock of the write window. If the bus changes partway through the window, the later values are kept.
- R4: The interrupt request rises only as the result of a committed write. It is high no later than the third rising clock edge after the write deasserts.
- R5: With `ctl_rd_n` low, `ctl_dout` shows one of the following, chosen by `ctl_sel`. Select 0x0 gives the held data and select 0x1 gives the held address. Select 0x2 gives a status byte, with bit 0 the interrupt request and bit 1 the overrun flag, and all other bits 0. Every other select reads 0x00. With `ctl_rd_n` high, `ctl_dout` is 0x00.
- R6: A read of select 0x0 completes when `ctl_rd_n` returns high, and this clears the interrupt request on the next clock. Reads of select 0x1 or 0x2 clear nothing.
- R7: A second write committed while the request is still pending sets the overrun flag, and the newest address and data replace the held ones.
- R8: Without a new write, the held address and data stay unchanged however long the controller waits, including across reads.
- R9: Completing a data read also clears the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_iorq_n | input | 1 | CPU I/O request, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cpu_addr_lo | input | 8 | Low byte of the CPU address bus (port number) |
| cpu_data | input | 8 | CPU data bus |
| ctl_sel | input | 4 | Controller register select |
| ctl_rd_n | input | 1 | Controller read strobe, active low |
| ctl_dout | output | 8 | Controller read data |
| ctl_irq | output | 1 | Interrupt request to the controller |

## Verification
Single writes with distinct address/data pairs show that the address and data land in separate holding registers and are not swapped or mixed. Half-strobes (only the request, or only the write line, low) separate the true two-signal decode from a single-signal one. A write whose bus values change mid-window shows whether the capture keeps the last values or the first. Back-to-back writes without an intervening read, reads of the address and status selects alone, and a long idle wait show that overrun, newest-wins overwrite, selective clearing and retention behave as required.

// File: rtl/mbx_pkg.sv
// Package: shared select codes and status bit positions for the mailbox.
// Assumes a 4-bit controller select on the mini-bus.
package mbx_pkg;
    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA   = 4'h0,
        SEL_ADDR   = 4'h1,
        SEL_STATUS = 4'h2
    } ctl_sel_e;

    localparam int ST_IRQ_BIT = 0;
    localparam int ST_OVR_BIT = 1;
endpackage

// File: rtl/mbx_wr_detect.sv
// Module: recognises a CPU I/O write and produces a one-clock commit pulse.
// The pulse fires when the synchronised write deasserts.
// Assumes the write stays active across at least two rising clock edges.
module mbx_wr_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic iorq_n,
    input  logic wr_n,
    output logic wr_live,
    output logic commit
);
    localparam int MSB = SYNC_STAGES - 1;

    logic             wr_raw_n;
    logic [MSB:0]     sync_q;
    logic             last_q;

    assign wr_raw_n = iorq_n | wr_n;
    assign wr_live  = ~wr_raw_n;

    // Purpose: bring the combined active-low write into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[MSB-1:0], wr_raw_n};
            last_q <= sync_q[MSB];
        end
    end

    // Purpose: flag the release (low-to-high) of the synchronised write.
    always_comb begin
        commit = sync_q[MSB] & ~last_q;
    end
endmodule

// File: rtl/mbx_capture.sv
// Module: staging and holding registers, plus the request and overrun flags.
// Staging follows the bus while the write is active. Commit copies the
// staged values into the holding registers.
// Assumes consecutive writes are at least four clocks apart.
module mbx_capture #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_live,
    input  logic              commit,
    input  logic              done,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] held_addr,
    output logic [DATA_W-1:0] held_data,
    output logic              irq,
    output logic              ovr
);
    logic [ADDR_W-1:0] stage_addr;
    logic [DATA_W-1:0] stage_data;

    // Purpose: track the bus during the write window, keeping the last values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_addr <= '0;
            stage_data <= '0;
        end else if (wr_live) begin
            stage_addr <= addr_in;
            stage_data <= data_in;
        end
    end

    // Purpose: hold the committed values until the next commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
            held_data <= '0;
        end else if (commit) begin
            held_addr <= stage_addr;
            held_data <= stage_data;
        end
    end

    // Purpose: raise the request on commit, flag overrun, clear on completed read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            ovr <= 1'b0;
        end else if (commit) begin
            irq <= 1'b1;
            if (irq && !done) begin
                ovr <= 1'b1;
            end else if (done) begin
                ovr <= 1'b0;
            end
        end else if (done) begin
            irq <= 1'b0;
            ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/mbx_ctl_port.sv
// Module: controller-side read multiplexer and read-completion detector.
// Assumes the controller's strobe and select are synchronous to clk.
module mbx_ctl_port #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [mbx_pkg::SEL_W-1:0] sel,
    input  logic                    rd_n,
    input  logic [ADDR_W-1:0]       held_addr,
    input  logic [DATA_W-1:0]       held_data,
    input  logic                    irq,
    input  logic                    ovr,
    output logic [DATA_W-1:0]       dout,
    output logic                    done
);
    import mbx_pkg::*;

    logic              rd_data_q;
    logic [DATA_W-1:0] status;

    // Purpose: assemble the status byte from the two flags.
    always_comb begin
        status             = '0;
        status[ST_IRQ_BIT] = irq;
        status[ST_OVR_BIT] = ovr;
    end

    // Purpose: drive the selected register while the strobe is low, else zero.
    always_comb begin
        dout = '0;
        if (!rd_n) begin
            case (sel)
                SEL_DATA:   dout = held_data;
                SEL_ADDR:   dout = DATA_W'(held_addr);
                SEL_STATUS: dout = status;
                default:    dout = '0;
            endcase
        end
    end

    // Purpose: remember that a data-select read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= 1'b0;
        end else begin
            rd_data_q <= !rd_n && (sel == SEL_DATA);
        end
    end

    // Purpose: signal completion when the data-read strobe is released.
    always_comb begin
        done = rd_data_q & rd_n;
    end
endmodule

// File: rtl/iowr_mailbox.sv
// Module: top of the port-write capture mailbox.
// Captures CPU I/O writes, interrupts the controller, and serves readback.
// Assumes the CPU strobes are asynchronous and the controller is synchronous.
module iowr_mailbox #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_iorq_n,
    input  logic              cpu_wr_n,
    input  logic [ADDR_W-1:0] cpu_addr_lo,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic [3:0]        ctl_sel,
    input  logic              ctl_rd_n,
    output logic [DATA_W-1:0] ctl_dout,
    output logic              ctl_irq
);
    logic              wr_live;
    logic              commit;
    logic              done;
    logic              ovr;
    logic [ADDR_W-1:0] held_addr;
    logic [DATA_W-1:0] held_data;

    mbx_wr_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .iorq_n  (cpu_iorq_n),
        .wr_n    (cpu_wr_n),
        .wr_live (wr_live),
        .commit  (commit)
    );

    mbx_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_live   (wr_live),
        .commit    (commit),
        .done      (done),
        .addr_in   (cpu_addr_lo),
        .data_in   (cpu_data),
        .held_addr (held_addr),
        .held_data (held_data),
        .irq       (ctl_irq),
        .ovr       (ovr)
    );

    mbx_ctl_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (ctl_sel),
        .rd_n      (ctl_rd_n),
        .held_addr (held_addr),
        .held_data (held_data),
        .irq       (ctl_irq),
        .ovr       (ovr),
        .dout      (ctl_dout),
        .done      (done)
    );
endmodule

// File: rtl/iowr_mailbox_chk.sv
// Checker: temporal properties of the mailbox, bound into the top module.
module iowr_mailbox_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_rd_n,
    input logic [DATA_W-1:0] ctl_dout,
    input logic              ctl_irq,
    input logic              ovr,
    input logic              commit,
    input logic              done,
    input logic [ADDR_W-1:0] held_addr,
    input logic [DATA_W-1:0] held_data
);
    AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd_n |-> (ctl_dout == '0));                                   // R5

    AST_IRQ_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_irq) |-> $past(commit));                                // R4

    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !commit) |=> !ctl_irq);                                  // R6

    AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !commit) |=> !ovr);                                      // R9

    AST_OVR_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> ctl_irq);                                                 // R7

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(commit) |-> ($stable(held_addr) && $stable(held_data)));   // R8
endmodule

bind iowr_mailbox iowr_mailbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_rd_n  (ctl_rd_n),
    .ctl_dout  (ctl_dout),
    .ctl_irq   (ctl_irq),
    .ovr       (ovr),
    .commit    (commit),
    .done      (done),
    .held_addr (held_addr),
    .held_data (held_data)
);

// File: tb/sim_iowr_mailbox.sv
module sim_iowr_mailbox;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_iorq_n = 1'b1;
    logic       cpu_wr_n = 1'b1;
    logic [7:0] cpu_addr_lo = 8'h00;
    logic [7:0] cpu_data = 8'h00;
    logic [3:0] ctl_sel = 4'h0;
    logic       ctl_rd_n = 1'b1;
    logic [7:0] ctl_dout;
    logic       ctl_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    iowr_mailbox u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_iorq_n  (cpu_iorq_n),
        .cpu_wr_n    (cpu_wr_n),
        .cpu_addr_lo (cpu_addr_lo),
        .cpu_data    (cpu_data),
        .ctl_sel     (ctl_sel),
        .ctl_rd_n    (ctl_rd_n),
        .ctl_dout    (ctl_dout),
        .ctl_irq     (ctl_irq)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One CPU write; the bus changes to mid_a/mid_d after two clocks.
    task automatic cpu_write(input logic [7:0] a, input logic [7:0] d,
                             input logic [7:0] mid_a, input logic [7:0] mid_d);
        @(negedge clk);
        cpu_addr_lo = a; cpu_data = d;
        cpu_iorq_n = 1'b0; cpu_wr_n = 1'b0;
        idle(2);
        cpu_addr_lo = mid_a; cpu_data = mid_d;
        idle(2);
        cpu_iorq_n = 1'b1; cpu_wr_n = 1'b1;
        cpu_addr_lo = 8'hEE; cpu_data = 8'hEE;
        idle(3);
    endtask

    // Controller read: strobe low one clock, sample, release, settle.
    task automatic ctl_read(input logic [3:0] sel, output logic [7:0] val);
        @(negedge clk);
        ctl_sel = sel; ctl_rd_n = 1'b0;
        #1 val = ctl_dout;
        @(negedge clk);
        ctl_rd_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 irq", ctl_irq, 0);
        check("R1 dout idle", ctl_dout, 0);
        ctl_read(4'h0, v); check("R1 data", v, 8'h00);
        ctl_read(4'h1, v); check("R1 addr", v, 8'h00);
        ctl_read(4'h2, v); check("R1 status", v, 8'h00);
    endtask

    task automatic t_half_strobes();
        logic [7:0] v;
        @(negedge clk);
        cpu_addr_lo = 8'h11; cpu_data = 8'h22; cpu_iorq_n = 1'b0;
        idle(4); cpu_iorq_n = 1'b1; idle(4);
        check("R2 iorq alone irq", ctl_irq, 0);
        cpu_wr_n = 1'b0; idle(4); cpu_wr_n = 1'b1; idle(4);
        check("R2 wr alone irq", ctl_irq, 0);
        ctl_read(4'h0, v); check("R2 data unchanged", v, 8'h00);
    endtask

    task automatic t_single_write();
        logic [7:0] v;
        cpu_write(8'h3C, 8'h5A, 8'h3C, 8'hA5);
        check("R4 irq after write", ctl_irq, 1);
        ctl_read(4'h1, v); check("R5 addr select", v, 8'h3C);
        check("R6 addr read keeps irq", ctl_irq, 1);
        ctl_read(4'h2, v); check("R5 status irq only", v, 8'h01);
        check("R6 status read keeps irq", ctl_irq, 1);
        ctl_read(4'h7, v); check("R5 unused select", v, 8'h00);
        ctl_read(4'h0, v); check("R3 last data kept", v, 8'hA5);
        check("R6 data read clears irq", ctl_irq, 0);
        check("R5 dout idle", ctl_dout, 0);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        cpu_write(8'h10, 8'h01, 8'h10, 8'h01);
        cpu_write(8'h90, 8'hC3, 8'h91, 8'hC3);
        ctl_read(4'h2, v); check("R7 status overrun", v, 8'h03);
        ctl_read(4'h1, v); check("R7 newest addr", v, 8'h91);
        ctl_read(4'h0, v); check("R7 newest data", v, 8'hC3);
        ctl_read(4'h2, v); check("R9 status cleared", v, 8'h00);
    endtask

    task automatic t_late_read();
        logic [7:0] v;
        cpu_write(8'h7E, 8'h4D, 8'h7E, 8'h4D);
        idle(1000);
        check("R8 irq still pending", ctl_irq, 1);
        ctl_read(4'h1, v); check("R8 addr retained", v, 8'h7E);
        ctl_read(4'h0, v); check("R8 data retained", v, 8'h4D);
        ctl_read(4'h0, v); check("R8 data after reads", v, 8'h4D);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_half_strobes();
        t_single_write();
        t_overrun();
        t_late_read();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule